// File: doc/BRIEF.md
# Byte-Wide UV-Erasable PROM Control Model

This block is a synthesizable, clocked stand-in for the control side of a byte-wide ultraviolet-erasable programmable memory. Programmer logic under test can drive it in place of a real part. Its inputs are the active-low chip enable, output enable and program strobe, an address and a data byte. Two digital flags replace analog levels. One says the programming supply is raised. The other says the high identifier voltage is present on address bit 9.

From these inputs the model decodes the operating mode and decides whether it drives the data bus. It can also hold bytes in a small page buffer, commit byte or page programming, and return the identifier codes. The bidirectional bus is split into a data input, a data output and an output-drive flag.

Two behaviours make programmer retry loops testable. Programming can only clear bits. A write takes effect only after a configurable number of consecutive program pulses aimed at the same target. An erase-all input returns the whole array to the blank state.

Top module: `eprom_ctl_model`

## Requirements
- R1: With `vpp_hi`=0, `ce_n`=0 and `oe_n`=0 (read), `dout_en` is 1 and `dout` shows the stored byte at `addr` in the same cycle, unless the identifier readout of R8 applies.
- R2: With `vpp_hi`=0, `dout_en` is 0 whenever `ce_n`=1 (standby) or `oe_n`=1 (outputs off), and `pgm_n` has no effect.
- R3: With `vpp_hi`=1, the strobe pattern `ce_n`=0, `oe_n`=1, `pgm_n`=0 is a byte program of `din` at `addr`. A pulse is committed at the clock edge where `pgm_n` is first sampled 1 after a cycle sampled in this mode, using that cycle's address and data.
- R4: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1 is program-verify. `dout_en` is 1, `dout` shows the stored byte at `addr`, and `id_hv` is ignored.
- R5: With `vpp_hi`=1, `ce_n`=1, `oe_n`=0, `pgm_n`=1 stores `din` into page buffer slot `addr[1:0]` at the clock edge.
- R6: With `vpp_hi`=1, `ce_n`=1, `oe_n`=1, `pgm_n`=0 is page program, with `dout_en`=0. On strobe release the four buffered bytes are committed to the addresses {`addr[ADDR_W-1:2]`, slot}, slot 0 to 3.
- R7: Every other strobe pattern while `vpp_hi`=1 is program inhibit. `dout_en` is 0, and releasing the strobe after such a cycle changes no stored byte.
- R8: In read mode with `id_hv`=1, `dout` is 0x07 when `addr[0]`=0. When `addr[0]`=1 it is the device code: 0x38, or 0xB9 when `MASK_PINOUT`=1.
- R9: After reset, and from the clock edge after `erase_all` is sampled 1, every stored byte reads 0xFF. Erase wins over a same-edge commit.
- R10: A byte or page write takes effect only on the `PULSES`-th consecutive committed pulse to the same target, and on every later pulse to it. A target is the kind (byte or page) together with the byte address or page address. A pulse to a different target, an erase or a reset restarts the count at one.
- R11: A write stores the old byte AND the new data, so a stored 0 bit never returns to 1 without an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; blanks the array |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised flag |
| id_hv | input | 1 | Identifier voltage present on address bit 9 |
| erase_all | input | 1 | Blanks every byte to all ones |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data bus, input half |
| dout | output | DATA_W | Data bus, output half (0 when not driven) |
| dout_en | output | 1 | Data bus drive flag |

## Verification
The bench builds the model with `ADDR_W`=8, `PULSES`=3 and `MASK_PINOUT`=1. A three-pulse threshold leaves room for a verify after one and two pulses that still shows the blank byte, and for an interleaved pulse to another target that resets the count. With the mask-pinout variant selected, the 0xB9 device code is what the identifier readout must return. The small address space lets a single run program bytes, fill and commit a page, and clear bits on top of earlier writes.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

   typedef enum logic [2:0] {
      M_STANDBY,
      M_OUT_OFF,
      M_READ,
      M_PROG,
      M_VERIFY,
      M_PLATCH,
      M_PPROG,
      M_INHIBIT
   } mode_t;

   typedef enum logic [1:0] {
      PK_NONE,
      PK_BYTE,
      PK_PAGE
   } pend_t;

   localparam logic [7:0] MFR_CODE      = 8'h07;
   localparam logic [7:0] DEV_CODE_STD  = 8'h38;
   localparam logic [7:0] DEV_CODE_MASK = 8'hB9;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
   import eprom_pkg::*;
(
   input  logic  ce_n,
   input  logic  oe_n,
   input  logic  pgm_n,
   input  logic  vpp_hi,
   output mode_t mode
);

   always_comb begin
      if (!vpp_hi) begin
         if (ce_n)      mode = M_STANDBY;
         else if (oe_n) mode = M_OUT_OFF;
         else           mode = M_READ;
      end else begin
         unique case ({ce_n, oe_n, pgm_n})
            3'b010:  mode = M_PROG;
            3'b001:  mode = M_VERIFY;
            3'b101:  mode = M_PLATCH;
            3'b110:  mode = M_PPROG;
            default: mode = M_INHIBIT;
         endcase
      end
   end

endmodule

// File: rtl/eprom_page_buf.sv
module eprom_page_buf #(
   parameter int DATA_W = 8,
   parameter int SLOT_W = 2,
   localparam int PAGE_N = 1 << SLOT_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SLOT_W-1:0]              slot,
   input  logic [DATA_W-1:0]              din,
   output logic [PAGE_N-1:0][DATA_W-1:0]  page
);

   for (genvar s = 0; s < PAGE_N; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            page[s] <= '1;
         else if (wr_en && slot == SLOT_W'(s))
            page[s] <= din;
      end
   end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
   import eprom_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8,
   parameter int SLOT_W = 2,
   parameter int PULSES = 3,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int PAGE_N = 1 << SLOT_W,
   localparam int CNT_W  = $clog2(PULSES + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          erase_all,
   input  mode_t                         mode,
   input  logic                          pgm_n,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             din,
   input  logic [PAGE_N-1:0][DATA_W-1:0] page,
   output logic [DATA_W-1:0]             rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   // pulse captured in the cycle before the strobe release
   pend_t             pend_kind;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_data;
   logic              pgm_q;

   // retry bookkeeping: last committed target and its pulse count
   pend_t             last_kind;
   logic [ADDR_W-1:0] last_key;
   logic [CNT_W-1:0]  cnt;
   logic              cnt_ok;

   logic              rise, commit, same_tgt, do_write;
   logic [ADDR_W-1:0] tgt_key;
   logic [CNT_W-1:0]  cnt_next;

   assign rd_data = mem[addr];
   assign rise    = pgm_n && !pgm_q;
   assign commit  = rise && (pend_kind != PK_NONE);

   always_comb begin
      tgt_key = pend_addr;
      if (pend_kind == PK_PAGE) tgt_key[SLOT_W-1:0] = '0;
      same_tgt = cnt_ok && (last_kind == pend_kind) && (last_key == tgt_key);
      if (!same_tgt)                   cnt_next = CNT_W'(1);
      else if (cnt == CNT_W'(PULSES))  cnt_next = cnt;
      else                             cnt_next = cnt + CNT_W'(1);
      do_write = commit && (cnt_next >= CNT_W'(PULSES));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_kind <= PK_NONE;
         pend_addr <= '0;
         pend_data <= '0;
         pgm_q     <= 1'b1;
      end else begin
         pgm_q     <= pgm_n;
         pend_addr <= addr;
         pend_data <= din;
         case (mode)
            M_PROG:  pend_kind <= PK_BYTE;
            M_PPROG: pend_kind <= PK_PAGE;
            default: pend_kind <= PK_NONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_kind <= PK_NONE;
         last_key  <= '0;
         cnt       <= '0;
         cnt_ok    <= 1'b0;
      end else if (erase_all) begin
         cnt_ok    <= 1'b0;
         cnt       <= '0;
      end else if (commit) begin
         last_kind <= pend_kind;
         last_key  <= tgt_key;
         cnt       <= cnt_next;
         cnt_ok    <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (erase_all) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (do_write) begin
         if (pend_kind == PK_BYTE) begin
            mem[pend_addr] <= mem[pend_addr] & pend_data;
         end else begin
            for (int k = 0; k < PAGE_N; k++)
               mem[{pend_addr[ADDR_W-1:SLOT_W], SLOT_W'(k)}] <=
                  mem[{pend_addr[ADDR_W-1:SLOT_W], SLOT_W'(k)}] & page[k];
         end
      end
   end

endmodule

// File: rtl/eprom_ctl_model.sv
module eprom_ctl_model
   import eprom_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int PAGE_BYTES  = 4,
   parameter int PULSES      = 3,
   parameter bit MASK_PINOUT = 1'b0,
   localparam int SLOT_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              pgm_n,
   input  logic              vpp_hi,
   input  logic              id_hv,
   input  logic              erase_all,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   if (DATA_W != 8) begin : g_bad_width
      $error("eprom_ctl_model: identifier codes need DATA_W of 8");
   end
   if (PAGE_BYTES < 2 || (1 << SLOT_W) != PAGE_BYTES) begin : g_bad_page
      $error("eprom_ctl_model: PAGE_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= SLOT_W) begin : g_bad_addr
      $error("eprom_ctl_model: ADDR_W must exceed the page slot width");
   end
   if (PULSES < 1) begin : g_bad_pulses
      $error("eprom_ctl_model: PULSES must be at least 1");
   end

   mode_t                         mode;
   logic [PAGE_BYTES-1:0][DATA_W-1:0] page;
   logic [DATA_W-1:0]             cell_q;
   logic [DATA_W-1:0]             dev_code;
   logic                          id_sel;

   eprom_mode_dec u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .pgm_n  (pgm_n),
      .vpp_hi (vpp_hi),
      .mode   (mode)
   );

   eprom_page_buf #(
      .DATA_W (DATA_W),
      .SLOT_W (SLOT_W)
   ) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (mode == M_PLATCH),
      .slot  (addr[SLOT_W-1:0]),
      .din   (din),
      .page  (page)
   );

   eprom_cell_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SLOT_W (SLOT_W),
      .PULSES (PULSES)
   ) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase_all (erase_all),
      .mode      (mode),
      .pgm_n     (pgm_n),
      .addr      (addr),
      .din       (din),
      .page      (page),
      .rd_data   (cell_q)
   );

   if (MASK_PINOUT) begin : g_dev_mask
      assign dev_code = DATA_W'(DEV_CODE_MASK);
   end else begin : g_dev_std
      assign dev_code = DATA_W'(DEV_CODE_STD);
   end

   assign id_sel  = (mode == M_READ) && id_hv;
   assign dout_en = (mode == M_READ) || (mode == M_VERIFY);

   always_comb begin
      if (!dout_en)   dout = '0;
      else if (id_sel) dout = addr[0] ? dev_code : DATA_W'(MFR_CODE);
      else            dout = cell_q;
   end

endmodule

// File: rtl/eprom_ctl_chk.sv
module eprom_ctl_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              pgm_n,
   input logic              vpp_hi,
   input logic              id_hv,
   input logic              erase_all,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);

   logic data_read;
   assign data_read = dout_en && (vpp_hi || !id_hv);

   // R2
   standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_hi && ce_n) |-> !dout_en);

   // R6
   page_prog_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_hi && ce_n && oe_n && !pgm_n) |-> !dout_en);

   // R8
   mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_hi && !ce_n && !oe_n && id_hv && !addr[0]) |-> (dout_en && dout == DATA_W'(8'h07)));

   // R9
   erase_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_all |=> (!data_read || dout == '1));

   // R11
   bits_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_read && $past(data_read) && addr == $past(addr) && !$past(erase_all))
         |-> ((dout & ~$past(dout)) == '0));

endmodule

bind eprom_ctl_model eprom_ctl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .oe_n      (oe_n),
   .pgm_n     (pgm_n),
   .vpp_hi    (vpp_hi),
   .id_hv     (id_hv),
   .erase_all (erase_all),
   .addr      (addr),
   .dout      (dout),
   .dout_en   (dout_en)
);

// File: tb/eprom_ctl_model_test.sv
module eprom_ctl_model_test;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int NP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
   logic          vpp_hi = 1'b0, id_hv = 1'b0, erase_all = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int vectors = 0;
   int errors  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   eprom_ctl_model #(
      .ADDR_W      (AW),
      .DATA_W      (DW),
      .PAGE_BYTES  (4),
      .PULSES      (NP),
      .MASK_PINOUT (1'b1)
   ) uut (
      .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .pgm_n (pgm_n),
      .vpp_hi (vpp_hi), .id_hv (id_hv), .erase_all (erase_all),
      .addr (addr), .din (din), .dout (dout), .dout_en (dout_en)
   );

   // reference state
   logic [7:0] m_mem [256];
   logic [7:0] m_lat [4];
   bit         m_pgm_q;
   int         m_pend;      // 0 none, 1 byte, 2 page
   int         m_paddr;
   logic [7:0] m_pdata;
   int         m_lkind, m_lkey, m_cnt;
   bit         m_cok;

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
      for (int i = 0; i < 4; i++) m_lat[i] = 8'hFF;
      m_pgm_q = 1; m_pend = 0; m_paddr = 0; m_pdata = 0;
      m_lkind = 0; m_lkey = 0; m_cnt = 0; m_cok = 0;
   endtask

   task automatic check(string tag, bit exp_en, logic [7:0] exp_d);
      vectors++;
      if (dout_en !== exp_en || (exp_en && dout !== exp_d)) begin
         errors++;
         $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h (addr=%02h)",
                  tag, dout_en, dout, exp_en, exp_d, addr);
      end
   endtask

   // one clock: drive at falling edge, compare, advance the model at rising edge
   task automatic step(string tag, bit c, bit o, bit p, bit v, bit idv,
                       int a, logic [7:0] d, bit er = 0);
      bit         en;
      logic [7:0] ed;
      bit         rise;
      int         key, k;
      @(negedge clk);
      ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = idv;
      addr = AW'(a); din = d; erase_all = er;
      #2;
      en = 0; ed = 8'h00;
      if (!v) begin
         if (!c && !o) begin
            en = 1;
            ed = idv ? (a[0] ? 8'hB9 : 8'h07) : m_mem[a];
         end
      end else if ({c, o, p} == 3'b001) begin
         en = 1; ed = m_mem[a];
      end
      check(tag, en, ed);
      rise = p && !m_pgm_q;
      if (er) begin
         for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
         m_cok = 0; m_cnt = 0;
      end else if (rise && m_pend != 0) begin
         key = (m_pend == 2) ? (m_paddr & ~3) : m_paddr;
         if (m_cok && m_lkind == m_pend && m_lkey == key)
            m_cnt = (m_cnt < NP) ? m_cnt + 1 : m_cnt;
         else
            m_cnt = 1;
         m_cok = 1; m_lkind = m_pend; m_lkey = key;
         if (m_cnt >= NP) begin
            if (m_pend == 1) m_mem[m_paddr] = m_mem[m_paddr] & m_pdata;
            else for (int j = 0; j < 4; j++) begin
               k = key + j;
               m_mem[k] = m_mem[k] & m_lat[j];
            end
         end
      end
      if (v && {c, o, p} == 3'b101) m_lat[a % 4] = d;
      m_pend = !v ? 0 : ({c, o, p} == 3'b010) ? 1 : ({c, o, p} == 3'b110) ? 2 : 0;
      m_paddr = a; m_pdata = d; m_pgm_q = p;
   endtask

   // one byte program pulse followed by a verify of the same address
   task automatic byte_pulse(string tag, int a, logic [7:0] d);
      step(tag, 0, 1, 0, 1, 0, a, d);
      step(tag, 0, 1, 0, 1, 0, a, d);
      step(tag, 0, 1, 1, 1, 0, a, d);
      step(tag, 0, 0, 1, 1, 0, a, 8'h00);
   endtask

   task automatic rd(string tag, int a, bit idv = 0);
      step(tag, 0, 0, 1, 0, idv, a, 8'h00);
   endtask

   initial begin : watchdog
      #400000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state: outputs idle
      vectors++;
      if (dout_en !== 1'b0) begin
         errors++;
         $display("FAIL R9 reset: dout_en=%0b expected 0", dout_en);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1 / R9 blank reads
      rd("R1_blank", 5);
      rd("R9_blank", 8'hFE);
      // R2 outputs off, standby, strobe ignored
      step("R2_outoff", 0, 1, 1, 0, 0, 5, 8'h00);
      step("R2_standby", 1, 0, 1, 0, 0, 5, 8'h00);
      step("R2_pgm_ignored", 0, 1, 0, 0, 0, 5, 8'h00);
      step("R2_pgm_release", 0, 1, 1, 0, 0, 5, 8'h00);
      rd("R2_unchanged", 5);

      // R3 R10 byte program needs three pulses; R4 verify shows progress
      byte_pulse("R10_pulse1", 8'h10, 8'hA5);
      byte_pulse("R10_pulse2", 8'h10, 8'hA5);
      byte_pulse("R3_pulse3", 8'h10, 8'hA5);
      byte_pulse("R10_pulse4", 8'h10, 8'hA5);
      rd("R3_readback", 8'h10);
      // R4 verify ignores the identifier flag
      step("R4_verify_id", 0, 0, 1, 1, 1, 8'h11, 8'h00);

      // R11 only clears bits
      for (int i = 0; i < NP; i++) byte_pulse("R11_and", 8'h10, 8'h5A);
      rd("R11_result", 8'h10);

      // R10 a different target restarts the count
      byte_pulse("R10_a1", 8'h20, 8'h3C);
      byte_pulse("R10_other", 8'h21, 8'h0F);
      byte_pulse("R10_a2", 8'h20, 8'h3C);
      byte_pulse("R10_a3", 8'h20, 8'h3C);
      byte_pulse("R10_a4", 8'h20, 8'h3C);
      rd("R10_read20", 8'h20);
      rd("R10_read21", 8'h21);

      // R5 fill page buffer out of order; R6 page program
      step("R5_latch", 1, 0, 1, 1, 0, 8'h42, 8'h11);
      step("R5_latch", 1, 0, 1, 1, 0, 8'h40, 8'hC3);
      step("R5_latch", 1, 0, 1, 1, 0, 8'h43, 8'h7E);
      step("R5_latch", 1, 0, 1, 1, 0, 8'h41, 8'h24);
      for (int i = 0; i < NP; i++) begin
         step("R6_pprog", 1, 1, 0, 1, 0, 8'h42, 8'h00);
         step("R6_pprog", 1, 1, 0, 1, 0, 8'h42, 8'h00);
         step("R6_release", 1, 1, 1, 1, 0, 8'h42, 8'h00);
         step("R6_verify", 0, 0, 1, 1, 0, 8'h40, 8'h00);
      end
      for (int i = 0; i < 4; i++) rd("R6_page_read", 8'h40 + i);
      rd("R6_neighbour", 8'h44);

      // R7 inhibit patterns with strobe activity change nothing
      for (int i = 0; i < NP + 1; i++) begin
         step("R7_inhibit", 0, 0, 0, 1, 0, 8'h30, 8'h00);
         step("R7_inhibit", 0, 0, 1, 1, 0, 8'h30, 8'h00);
         step("R7_inhibit", 1, 1, 1, 1, 0, 8'h31, 8'h00);
         step("R7_inhibit", 1, 0, 0, 1, 0, 8'h31, 8'h00);
         step("R7_inhibit", 1, 1, 1, 1, 0, 8'h31, 8'h00);
      end
      rd("R7_read30", 8'h30);
      rd("R7_read31", 8'h31);

      // R8 identifier readout
      rd("R8_mfr", 0, 1);
      rd("R8_dev", 1, 1);
      rd("R8_mfr_hiaddr", 8'h40, 1);
      rd("R8_dev_hiaddr", 8'h41, 1);

      // R9 erase: same-edge commit loses
      step("R9_pend", 0, 1, 0, 1, 0, 8'h50, 8'h00);
      step("R9_erase", 0, 1, 1, 1, 0, 8'h50, 8'h00, 1);
      rd("R9_after10", 8'h10);
      rd("R9_after40", 8'h40);
      rd("R9_after50", 8'h50);
      // R10 erase restarts the count
      byte_pulse("R10_post_erase1", 8'h60, 8'h00);
      byte_pulse("R10_post_erase2", 8'h60, 8'h00);
      byte_pulse("R10_post_erase3", 8'h60, 8'h00);
      rd("R10_read60", 8'h60);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule